// File: doc/BRIEF.md
# Peripheral Power Gating Controller

This block decides, for each of a set of peripheral slots, whether the slot receives a clock, whether its registers may be reached from the register bus, and whether its function runs. It offers two levels of shutdown. A hard shutdown bit removes the slot's clock and cuts it off from the bus. A softer enable bit stops only the function and leaves the registers usable. A third bit per slot halts the slot while the chip-wide idle input is high.

The three control masks sit on a control page of the block's own register space. Every other bus request is passed on to the addressed slot as a one-hot select, unless that slot is shut down. A request to a shut-down slot is swallowed: writes do nothing, reads return zero, and the bus still receives its ready pulse.

When the hard shutdown bit is released, the slot gets a one-cycle register reset pulse. Bus access returns only after that pulse. Slots built without an enable bit report that bit as permanently set.

Top module: `periph_power_gate`

## Requirements
- R1: After reset all three masks are 0. `clkEn` and `regAccessEn` are all ones, `funcEn` equals the inverse of the `HAS_EN` parameter, and `regReset` and `busReady` are 0.
- R2: A slot whose shutdown bit is set has `clkEn`, `regAccessEn` and `funcEn` all at 0, whatever its enable bit, its idle bit and `sysIdle` say.
- R3: A bus request to a shut-down slot raises no `slotSel` bit. A read of it returns 0, and `busReady` still pulses.
- R4: A slot that has an enable bit but has it cleared has `funcEn` at 0 and `clkEn` and `regAccessEn` at 1. Its register reads and writes are forwarded.
- R5: With `sysIdle` at 1, a slot whose idle-stop bit is 1 has `clkEn` and `funcEn` at 0 and `regAccessEn` at 1. With that bit at 0, `sysIdle` has no effect on the slot.
- R6: For a slot with `HAS_EN[i]` at 0, its enable bit reads as 1 and writes to it are ignored. Its `funcEn` is 1 unless the slot is shut down or halted by idle.
- R7: A write that clears a slot's shutdown bit makes `regReset` for that slot 1 for exactly one cycle, starting right after the write edge. `regAccessEn` is 0 during that cycle and 1 afterwards. The slot's enable and idle-stop bits read 0 afterwards.
- R8: `busReady` is 1 in the cycle after each accepted request and 0 otherwise. Read data comes from the addressed slot's `slotRdata` as sampled in the request cycle. `slotSel` is one-hot and combinational in the request cycle.
- R9: `busAddr[ADDR_W-1]`=1 selects the control page, whose index is `busAddr[1:0]`: 0 is the shutdown mask, 1 the enable mask, 2 the idle-stop mask and 3 reads 0. Bit i of each mask belongs to slot i. A value written reads back, except that enable and idle-stop writes to shut-down slots are ignored.
- R10: With `busAddr[ADDR_W-1]`=0, the slot is `busAddr[REG_W +: SLOT_W]` and the register is `busAddr[REG_W-1:0]`, which is forwarded on `slotRegAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysIdle | input | 1 | Chip-wide idle state |
| busValid | input | 1 | Bus request strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Page, slot and register index |
| busWdata | input | DATA_W | Write data |
| busReady | output | 1 | Response strobe, one cycle after request |
| busRdata | output | DATA_W | Read data, valid with busReady |
| slotSel | output | NUM_SLOTS | One-hot forwarded request |
| slotWrite | output | 1 | Forwarded write flag |
| slotRegAddr | output | REG_W | Forwarded register index |
| slotWdata | output | DATA_W | Forwarded write data |
| slotRdata | input | NUM_SLOTS*DATA_W | Per-slot read data, slot i at bits i*DATA_W |
| clkEn | output | NUM_SLOTS | Per-slot clock enable |
| regAccessEn | output | NUM_SLOTS | Per-slot register access allowed |
| funcEn | output | NUM_SLOTS | Per-slot function enable |
| regReset | output | NUM_SLOTS | Per-slot register reset pulse |

## Verification
The gating outputs and `regReset` change on the edge that takes a control write, so the bench samples them on the falling edge right after that edge. It samples `regReset` once more a cycle later to see the pulse end. `slotSel` is combinational, so it is checked one time step after the request is driven, inside the same cycle. Every request pushes its expected response onto a queue. A monitor pops one entry at each falling edge where `busReady` is high, so read data is compared exactly one cycle after its request, and a ready with an empty queue counts as a failure.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef enum logic [1:0] {
    CTL_SHUT  = 2'd0,
    CTL_EN    = 2'd1,
    CTL_IDLE  = 2'd2,
    CTL_SPARE = 2'd3
  } ctlReg_e;

  typedef struct packed {
    logic    ctlWrite;
    logic    ctlRead;
    ctlReg_e ctlReg;
    logic    slotWrite;
    logic    slotRead;
  } pgStrobe_t;

endpackage

// File: rtl/pg_bus_decode.sv
module pg_bus_decode
  import pg_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int REG_W     = 2,
  parameter int SLOT_W    = 3,
  parameter int ADDR_W    = 6
) (
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  output pgStrobe_t            strobe,
  output logic [NUM_SLOTS-1:0] slotHit
);

  logic              ctlPage;
  logic [SLOT_W-1:0] slotIdx;

  assign ctlPage = busAddr[ADDR_W-1];
  assign slotIdx = busAddr[REG_W +: SLOT_W];

  always_comb begin
    strobe        = '0;
    strobe.ctlReg = ctlReg_e'(busAddr[1:0]);
    if (busValid) begin
      if (ctlPage) begin
        strobe.ctlWrite = busWrite;
        strobe.ctlRead  = !busWrite;
      end else begin
        strobe.slotWrite = busWrite;
        strobe.slotRead  = !busWrite;
      end
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
    assign slotHit[i] = busValid && !ctlPage && (slotIdx == SLOT_W'(i));
  end

endmodule

// File: rtl/pg_gate_core.sv
module pg_gate_core
  import pg_pkg::*;
#(
  parameter int                   NUM_SLOTS = 8,
  parameter int                   DATA_W    = 16,
  parameter logic [NUM_SLOTS-1:0] HAS_EN    = '1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sysIdle,
  input  pgStrobe_t                   strobe,
  input  logic [NUM_SLOTS-1:0]        slotHit,
  input  logic [DATA_W-1:0]           busWdata,
  input  logic [NUM_SLOTS*DATA_W-1:0] slotRdata,
  output logic [NUM_SLOTS-1:0]        slotSel,
  output logic [NUM_SLOTS-1:0]        clkEn,
  output logic [NUM_SLOTS-1:0]        regAccessEn,
  output logic [NUM_SLOTS-1:0]        funcEn,
  output logic [NUM_SLOTS-1:0]        regReset,
  output logic                        busReady,
  output logic [DATA_W-1:0]           busRdata
);

  logic [NUM_SLOTS-1:0] shutQ, shutNext, pendQ;
  logic [NUM_SLOTS-1:0] enEff, idleStopQ, haltIdle, wdMask;
  logic                 wrEn, wrIdle;
  logic [DATA_W-1:0]    ctlRd, slotRd;

  assign wdMask = busWdata[NUM_SLOTS-1:0];
  assign wrEn   = strobe.ctlWrite && (strobe.ctlReg == CTL_EN);
  assign wrIdle = strobe.ctlWrite && (strobe.ctlReg == CTL_IDLE);

  always_comb begin
    shutNext = shutQ;
    if (strobe.ctlWrite && (strobe.ctlReg == CTL_SHUT)) shutNext = wdMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shutQ <= '0;
      pendQ <= '0;
    end else begin
      shutQ <= shutNext;
      pendQ <= shutQ & ~shutNext;
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic idleQ;
    always_ff @(posedge clk) begin
      if (!rstN || shutQ[i] || pendQ[i]) idleQ <= 1'b0;
      else if (wrIdle) idleQ <= wdMask[i];
    end
    assign idleStopQ[i] = idleQ;

    if (HAS_EN[i]) begin : g_en
      logic enQ;
      always_ff @(posedge clk) begin
        if (!rstN || shutQ[i] || pendQ[i]) enQ <= 1'b0;
        else if (wrEn) enQ <= wdMask[i];
      end
      assign enEff[i] = enQ;
    end else begin : g_no_en
      assign enEff[i] = 1'b1;
    end
  end

  assign haltIdle    = {NUM_SLOTS{sysIdle}} & idleStopQ;
  assign clkEn       = ~shutQ & ~haltIdle;
  assign regAccessEn = ~shutQ & ~pendQ;
  assign funcEn      = clkEn & regAccessEn & enEff;
  assign regReset    = pendQ;
  assign slotSel     = (strobe.slotWrite || strobe.slotRead) ? (slotHit & regAccessEn) : '0;

  always_comb begin
    ctlRd = '0;
    unique case (strobe.ctlReg)
      CTL_SHUT:  ctlRd[NUM_SLOTS-1:0] = shutQ;
      CTL_EN:    ctlRd[NUM_SLOTS-1:0] = enEff;
      CTL_IDLE:  ctlRd[NUM_SLOTS-1:0] = idleStopQ;
      default:   ctlRd = '0;
    endcase
  end

  always_comb begin
    slotRd = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slotSel[i]) slotRd = slotRd | slotRdata[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busReady <= 1'b0;
      busRdata <= '0;
    end else begin
      busReady <= strobe.ctlWrite | strobe.ctlRead | strobe.slotWrite | strobe.slotRead;
      if (strobe.ctlRead)       busRdata <= ctlRd;
      else if (strobe.slotRead) busRdata <= slotRd;
      else                      busRdata <= '0;
    end
  end

endmodule

// File: rtl/periph_power_gate.sv
module periph_power_gate
  import pg_pkg::*;
#(
  parameter int                   NUM_SLOTS = 8,
  parameter int                   DATA_W    = 16,
  parameter int                   REG_W     = 2,
  parameter logic [NUM_SLOTS-1:0] HAS_EN    = 8'h3F,
  localparam int                  SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int                  ADDR_W    = 1 + SLOT_W + REG_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sysIdle,
  input  logic                        busValid,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [DATA_W-1:0]           busWdata,
  output logic                        busReady,
  output logic [DATA_W-1:0]           busRdata,
  output logic [NUM_SLOTS-1:0]        slotSel,
  output logic                        slotWrite,
  output logic [REG_W-1:0]            slotRegAddr,
  output logic [DATA_W-1:0]           slotWdata,
  input  logic [NUM_SLOTS*DATA_W-1:0] slotRdata,
  output logic [NUM_SLOTS-1:0]        clkEn,
  output logic [NUM_SLOTS-1:0]        regAccessEn,
  output logic [NUM_SLOTS-1:0]        funcEn,
  output logic [NUM_SLOTS-1:0]        regReset
);

  pgStrobe_t            strobe;
  logic [NUM_SLOTS-1:0] slotHit;

  assign slotWrite   = busWrite;
  assign slotRegAddr = busAddr[REG_W-1:0];
  assign slotWdata   = busWdata;

  pg_bus_decode #(
    .NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .strobe(strobe), .slotHit(slotHit)
  );

  pg_gate_core #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .HAS_EN(HAS_EN)
  ) u_core (
    .clk(clk), .rstN(rstN), .sysIdle(sysIdle), .strobe(strobe), .slotHit(slotHit),
    .busWdata(busWdata), .slotRdata(slotRdata), .slotSel(slotSel), .clkEn(clkEn),
    .regAccessEn(regAccessEn), .funcEn(funcEn), .regReset(regReset),
    .busReady(busReady), .busRdata(busRdata)
  );

endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 16,
  parameter int REG_W     = 2,
  parameter int SLOT_W    = 3,
  parameter int ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busReady,
  input logic [DATA_W-1:0]    busRdata,
  input logic [NUM_SLOTS-1:0] slotSel,
  input logic [NUM_SLOTS-1:0] clkEn,
  input logic [NUM_SLOTS-1:0] regAccessEn,
  input logic [NUM_SLOTS-1:0] funcEn,
  input logic [NUM_SLOTS-1:0] regReset
);

  logic [SLOT_W-1:0] idx;
  logic              blockedRead;

  assign idx         = busAddr[REG_W +: SLOT_W];
  assign blockedRead = busValid && !busWrite && !busAddr[ADDR_W-1] && !regAccessEn[idx];

  assert_ready_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> busReady);

  assert_no_spurious_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !busReady);

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotSel));

  assert_func_needs_clock_R2: assert property (@(posedge clk) disable iff (!rstN)
    (funcEn & ~clkEn) == '0);

  assert_reset_blocks_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regReset & regAccessEn) == '0);

  assert_reset_single_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|regReset) |=> ((regReset & $past(regReset)) == '0));

  assert_masked_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    blockedRead |=> (busRdata == '0));

endmodule

bind periph_power_gate pg_checker #(
  .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .REG_W(REG_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .busReady(busReady), .busRdata(busRdata), .slotSel(slotSel), .clkEn(clkEn),
  .regAccessEn(regAccessEn), .funcEn(funcEn), .regReset(regReset)
);

// File: tb/sim_periph_power_gate.sv
module sim_periph_power_gate;

  localparam int N  = 8;
  localparam int DW = 16;
  localparam int RW = 2;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sysIdle = 1'b0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic          busReady;
  logic [DW-1:0] busRdata;
  logic [N-1:0]  slotSel, clkEn, regAccessEn, funcEn, regReset;
  logic          slotWrite;
  logic [RW-1:0] slotRegAddr;
  logic [DW-1:0] slotWdata;
  logic [N*DW-1:0] slotRdata;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  logic [DW-1:0] expData[$];
  bit            expRead[$];
  string         expReq[$];

  logic [DW-1:0] mem [N][4];

  always #2 clk = ~clk;

  periph_power_gate #(.NUM_SLOTS(N), .DATA_W(DW), .REG_W(RW), .HAS_EN(8'h3F)) u0 (
    .clk(clk), .rstN(rstN), .sysIdle(sysIdle), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .slotSel(slotSel), .slotWrite(slotWrite), .slotRegAddr(slotRegAddr),
    .slotWdata(slotWdata), .slotRdata(slotRdata), .clkEn(clkEn),
    .regAccessEn(regAccessEn), .funcEn(funcEn), .regReset(regReset)
  );

  function automatic logic [DW-1:0] resetVal(int s, int r);
    return DW'(16'h1000 + s * 16 + r);
  endfunction

  // Peripheral register model
  always_ff @(posedge clk) begin
    for (int s = 0; s < N; s++) begin
      for (int r = 0; r < 4; r++) begin
        if (!rstN || regReset[s]) mem[s][r] <= resetVal(s, r);
        else if (slotSel[s] && slotWrite && slotRegAddr == RW'(r)) mem[s][r] <= slotWdata;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < N; s++) slotRdata[s*DW +: DW] = mem[s][slotRegAddr];
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ctlAddr(int idx);
    return {1'b1, 3'b000, 2'(idx)};
  endfunction

  function automatic logic [AW-1:0] slotAddr(int s, int r);
    return {1'b0, 3'(s), 2'(r)};
  endfunction

  // Driver: one request, expected response queued, select checked in-cycle
  task automatic busOp(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                       logic [DW-1:0] exp, logic [N-1:0] expSel, string req);
    busValid = 1'b1;
    busWrite = wr;
    busAddr  = a;
    busWdata = wd;
    expData.push_back(exp);
    expRead.push_back(!wr);
    expReq.push_back(req);
    #1;
    check({req, " slotSel"}, 32'(slotSel), 32'(expSel));
    @(negedge clk);
    busValid = 1'b0;
    busWrite = 1'b0;
  endtask

  // Monitor: pops one expectation per ready pulse
  always @(negedge clk) begin
    if (rstN && busReady) begin
      if (expData.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R8 unexpected ready actual=1 expected=0");
      end else begin
        logic [DW-1:0] e;
        bit rd;
        string rq;
        e  = expData.pop_front();
        rd = expRead.pop_front();
        rq = expReq.pop_front();
        if (rd) check({rq, " rdata"}, 32'(busRdata), 32'(e));
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 clkEn", 32'(clkEn), 32'hFF);
    check("R1 regAccessEn", 32'(regAccessEn), 32'hFF);
    check("R1 funcEn", 32'(funcEn), 32'hC0);
    check("R1 regReset", 32'(regReset), 32'h00);
    check("R1 busReady", 32'(busReady), 32'h0);

    // R9 / R6 control page after reset
    busOp(0, ctlAddr(0), '0, 16'h0000, '0, "R9 shut read");
    busOp(0, ctlAddr(1), '0, 16'h00C0, '0, "R6 enable read");
    busOp(0, ctlAddr(2), '0, 16'h0000, '0, "R9 idle read");
    busOp(0, ctlAddr(3), '0, 16'h0000, '0, "R9 spare read");

    // R6 / R4 enable mask
    busOp(1, ctlAddr(1), 16'h00FF, '0, '0, "R9 enable write");
    busOp(0, ctlAddr(1), '0, 16'h00FF, '0, "R9 enable readback");
    check("R4 funcEn all", 32'(funcEn), 32'hFF);
    busOp(1, ctlAddr(1), 16'h000F, '0, '0, "R6 enable write");
    busOp(0, ctlAddr(1), '0, 16'h00CF, '0, "R6 no-enable slots read 1");
    check("R4 funcEn", 32'(funcEn), 32'hCF);
    check("R4 clkEn", 32'(clkEn), 32'hFF);
    check("R4 regAccessEn", 32'(regAccessEn), 32'hFF);

    // R4 / R8 / R10 slot access with enable cleared
    busOp(1, slotAddr(4, 1), 16'hBEEF, '0, 8'h10, "R4 slot4 write");
    busOp(0, slotAddr(4, 1), '0, 16'hBEEF, 8'h10, "R4 slot4 read");
    busOp(0, slotAddr(2, 3), '0, resetVal(2, 3), 8'h04, "R10 slot2 reg3");
    busOp(1, slotAddr(1, 0), 16'h1234, '0, 8'h02, "R8 slot1 write");
    busOp(0, slotAddr(1, 0), '0, 16'h1234, 8'h02, "R8 slot1 read");

    // R5 idle stop
    busOp(1, ctlAddr(2), 16'h0005, '0, '0, "R5 idle write");
    check("R5 no idle clkEn", 32'(clkEn), 32'hFF);
    sysIdle = 1'b1;
    #1;
    check("R5 idle clkEn", 32'(clkEn), 32'hFA);
    check("R5 idle funcEn", 32'(funcEn), 32'hCA);
    check("R5 idle regAccessEn", 32'(regAccessEn), 32'hFF);
    @(negedge clk);
    busOp(0, slotAddr(0, 0), '0, resetVal(0, 0), 8'h01, "R5 idle slot0 read");
    sysIdle = 1'b0;

    // R2 shutdown with priority
    busOp(1, ctlAddr(0), 16'h0083, '0, '0, "R2 shut write");
    check("R2 clkEn", 32'(clkEn), 32'h7C);
    check("R2 regAccessEn", 32'(regAccessEn), 32'h7C);
    check("R2 funcEn", 32'(funcEn), 32'h4C);
    busOp(1, ctlAddr(1), 16'h00FF, '0, '0, "R9 enable write shut");
    busOp(0, ctlAddr(1), '0, 16'h00FC, '0, "R9 enable ignored on shut");
    check("R2 funcEn priority", 32'(funcEn), 32'h7C);
    busOp(1, ctlAddr(2), 16'h0001, '0, '0, "R9 idle write shut");
    busOp(0, ctlAddr(2), '0, 16'h0000, '0, "R9 idle ignored on shut");
    busOp(1, ctlAddr(2), 16'h0004, '0, '0, "R5 idle slot2");
    sysIdle = 1'b1;
    #1;
    check("R2 idle clkEn", 32'(clkEn), 32'h78);
    @(negedge clk);
    sysIdle = 1'b0;

    // R3 blocked access
    busOp(1, slotAddr(1, 0), 16'hDEAD, '0, 8'h00, "R3 write blocked");
    busOp(0, slotAddr(1, 0), '0, 16'h0000, 8'h00, "R3 read zero");
    busOp(0, slotAddr(7, 2), '0, 16'h0000, 8'h00, "R3 slot7 read zero");

    // R7 release of slot 1
    busOp(1, ctlAddr(0), 16'h0081, '0, '0, "R7 release write");
    check("R7 regReset pulse", 32'(regReset), 32'h02);
    check("R7 access held", 32'(regAccessEn), 32'h7C);
    @(negedge clk);
    check("R7 regReset end", 32'(regReset), 32'h00);
    check("R7 access back", 32'(regAccessEn), 32'h7E);
    busOp(0, slotAddr(1, 0), '0, resetVal(1, 0), 8'h02, "R7 slot1 reset value");
    busOp(0, ctlAddr(1), '0, 16'h00FC, '0, "R7 enable cleared");
    busOp(0, ctlAddr(2), '0, 16'h0004, '0, "R7 idle cleared");
    busOp(0, ctlAddr(0), '0, 16'h0081, '0, "R9 shut readback");

    repeat (3) @(negedge clk);
    check("R8 queue drained", 32'(expData.size()), 32'd0);
    finishRun();
  end

endmodule